// File: doc/BRIEF.md
# System control and exception pend register bank

This block is a word-wide register bank on a simple read/write port. Software uses it to raise or withdraw the non-maskable, deferred service-call and periodic tick exceptions, to fire an external interrupt by number, to enable the three configurable fault handlers, to place the vector table and to ask for a system reset. The block also reports the exception state that the prioritisation logic around it supplies: the active vector, the highest pending vector and the pending and active flags of the system handlers.

The block does no prioritisation itself. Every effect of a write leaves as a one-cycle strobe or as a held register value. Every read returns its data on a registered output. An access to an offset that is not mapped raises an error flag for one cycle.

Top module: `sysctl_bank`

## Requirements
- R1: During reset and in the first cycle after it, every strobe, `err_o`, `rdata_o`, `fault_en_o` and `vtor_o` are zero. All results are registered: a write or read sampled on clock edge k shows on the outputs from edge k until edge k+1. `rdata_o` is zero in any cycle that follows no read.
- R2: A write to offset 0xD04 with bit 31 set pulses `nmi_set_o`.
- R3: A write to 0xD04 with bit 28 set pulses `psv_set_o`. Bit 27 pulses `psv_clr_o` only when bit 28 of the same word is clear.
- R4: A write to 0xD04 with bit 26 set pulses `tick_set_o`. Bit 25 pulses `tick_clr_o` only when bit 26 of the same word is clear.
- R5: A read of 0xD04 returns the active vector in bits 8:0, the pending vector in bits 20:12 (zero when `pend_vld_i` is low), the external-pending flag in bit 22, tick pending in bit 26, service-call pending in bit 28 and NMI pending in bit 31. All other bits are zero.
- R6: A write to 0xD0C acts only when bits 31:16 hold 0x05FA. In that case bit 2 gives a single-cycle `sysrst_o` pulse. A read of 0xD0C returns 0xFA050000.
- R7: A write to 0xD08 stores bits 31:7 of the word. `vtor_o` and a read of 0xD08 return that value with bits 6:0 zero.
- R8: Bits 16, 17 and 18 of 0xD24 are read/write enables for the memory-management, bus and usage faults, driven on `fault_en_o[2:0]`. A read also returns the active flags of memory, bus, usage, service call, debug, deferred service and tick in bits 0, 1, 3, 7, 8, 10 and 11, and the pending flags of usage, memory, bus and service call in bits 12 to 15.
- R9: A write to 0xF00 pulses `trig_vld_o` with `trig_num_o` equal to bits 8:0 when that number is below NUM_IRQ. Otherwise the write has no effect. `trig_num_o` is zero when `trig_vld_o` is low.
- R10: A read of offset 0x004 returns NUM_IRQ/32 - 1.
- R11: A read of an offset not listed in R5 to R8 and R10, or a write to an offset not listed in R2 to R4 and R6 to R9, returns zero data, changes no state and pulses `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| err_o | output | 1 | Unmapped access flag |
| act_vec_i | input | 9 | Active vector number |
| pend_vec_i | input | 9 | Highest pending vector number |
| pend_vld_i | input | 1 | A vector is pending |
| ext_pend_i | input | 1 | Some external interrupt is pending |
| nmi_pend_i | input | 1 | NMI pending state |
| psv_pend_i | input | 1 | Service-call pending state |
| tick_pend_i | input | 1 | Tick pending state |
| hnd_act_i | input | 7 | Active: mem, bus, usage, svc, debug, deferred svc, tick |
| hnd_pend_i | input | 4 | Pending: usage, mem, bus, svc |
| nmi_set_o | output | 1 | Set NMI pending |
| psv_set_o | output | 1 | Set service-call pending |
| psv_clr_o | output | 1 | Clear service-call pending |
| tick_set_o | output | 1 | Set tick pending |
| tick_clr_o | output | 1 | Clear tick pending |
| trig_vld_o | output | 1 | Software interrupt trigger |
| trig_num_o | output | 9 | Triggered interrupt number |
| fault_en_o | output | 3 | Enables: mem, bus, usage fault |
| vtor_o | output | 32 | Vector table base |
| sysrst_o | output | 1 | System reset request pulse |

## Verification
Every result of this block is due exactly one clock after the edge that sampled the access. This holds for strobes, the reset pulse, the error flag, read data and register updates alike. The bench drives an access just after a falling edge, and its reference model works out what the outputs should be. At the next falling edge, half a period after the sampling edge, it compares every output against that prediction, so each output is checked in the one cycle it is due. Read data for 0xD04 and 0xD24 is predicted from the status inputs held during that same cycle. A read that shares a cycle with a write to the same register is predicted from the value held before the write.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
    localparam int unsigned VEC_W = 9;

    localparam logic [11:0] OFS_TYPE = 12'h004;
    localparam logic [11:0] OFS_ICS  = 12'hD04;
    localparam logic [11:0] OFS_VTB  = 12'hD08;
    localparam logic [11:0] OFS_RST  = 12'hD0C;
    localparam logic [11:0] OFS_HND  = 12'hD24;
    localparam logic [11:0] OFS_TRIG = 12'hF00;

    localparam logic [15:0] RST_KEY    = 16'h05FA;
    localparam logic [31:0] RST_RDVAL  = 32'hFA05_0000;

    typedef struct packed {
        logic             nmi_set;
        logic             psv_set;
        logic             psv_clr;
        logic             tick_set;
        logic             tick_clr;
        logic             trig_vld;
        logic [VEC_W-1:0] trig_num;
        logic             rst_req;
        logic             vtb_we;
        logic             fen_we;
        logic             hit;
    } wr_eff_t;

    typedef struct packed {
        logic             nmi_set;
        logic             psv_set;
        logic             psv_clr;
        logic             tick_set;
        logic             tick_clr;
        logic             trig_vld;
        logic [VEC_W-1:0] trig_num;
        logic             rst_req;
        logic             err;
        logic [2:0]       fen;
        logic [24:0]      vtb_hi;
        logic [31:0]      rdata;
    } bank_t;
endpackage

// File: rtl/sysctl_wdec.sv
module sysctl_wdec
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic        wr_en_i,
    input  logic [11:0] addr_i,
    input  logic [31:0] wdata_i,
    output wr_eff_t     eff_o
);
    localparam logic [31:0] IRQ_LIM = 32'(NUM_IRQ);

    logic [31:0] trig_word;

    always_comb begin
        trig_word = {23'd0, wdata_i[VEC_W-1:0]};
        eff_o = '0;
        if (wr_en_i) begin
            unique case (addr_i)
                OFS_ICS: begin
                    eff_o.hit      = 1'b1;
                    eff_o.nmi_set  = wdata_i[31];
                    eff_o.psv_set  = wdata_i[28];
                    eff_o.psv_clr  = wdata_i[27] & ~wdata_i[28];
                    eff_o.tick_set = wdata_i[26];
                    eff_o.tick_clr = wdata_i[25] & ~wdata_i[26];
                end
                OFS_VTB: begin
                    eff_o.hit    = 1'b1;
                    eff_o.vtb_we = 1'b1;
                end
                OFS_RST: begin
                    eff_o.hit     = 1'b1;
                    eff_o.rst_req = (wdata_i[31:16] == RST_KEY) & wdata_i[2];
                end
                OFS_HND: begin
                    eff_o.hit    = 1'b1;
                    eff_o.fen_we = 1'b1;
                end
                OFS_TRIG: begin
                    eff_o.hit = 1'b1;
                    if (trig_word < IRQ_LIM) begin
                        eff_o.trig_vld = 1'b1;
                        eff_o.trig_num = wdata_i[VEC_W-1:0];
                    end
                end
                default: eff_o.hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/sysctl_rmux.sv
module sysctl_rmux
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic [11:0]      addr_i,
    input  logic [VEC_W-1:0] act_vec_i,
    input  logic [VEC_W-1:0] pend_vec_i,
    input  logic             pend_vld_i,
    input  logic             ext_pend_i,
    input  logic             nmi_pend_i,
    input  logic             psv_pend_i,
    input  logic             tick_pend_i,
    input  logic [6:0]       hnd_act_i,
    input  logic [3:0]       hnd_pend_i,
    input  logic [2:0]       fen_i,
    input  logic [24:0]      vtb_hi_i,
    output logic [31:0]      data_o,
    output logic             hit_o
);
    localparam logic [31:0] TYPE_VAL = 32'(NUM_IRQ / 32 - 1);
    localparam int          N_ACT    = 7;
    localparam int          ACT_POS [N_ACT] = '{0, 1, 3, 7, 8, 10, 11};

    logic [31:0] ics_word;
    logic [31:0] hnd_word;

    always_comb begin
        ics_word = '0;
        ics_word[VEC_W-1:0] = act_vec_i;
        if (pend_vld_i) ics_word[12 +: VEC_W] = pend_vec_i;
        ics_word[22] = ext_pend_i;
        ics_word[26] = tick_pend_i;
        ics_word[28] = psv_pend_i;
        ics_word[31] = nmi_pend_i;
    end

    always_comb begin
        hnd_word = '0;
        for (int i = 0; i < N_ACT; i++) begin
            hnd_word[ACT_POS[i]] = hnd_act_i[i];
        end
        hnd_word[15:12] = hnd_pend_i;
        hnd_word[18:16] = fen_i;
    end

    always_comb begin
        hit_o  = 1'b1;
        data_o = '0;
        unique case (addr_i)
            OFS_TYPE: data_o = TYPE_VAL;
            OFS_ICS:  data_o = ics_word;
            OFS_VTB:  data_o = {vtb_hi_i, 7'd0};
            OFS_RST:  data_o = RST_RDVAL;
            OFS_HND:  data_o = hnd_word;
            default:  hit_o  = 1'b0;
        endcase
    end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en_i,
    input  logic             rd_en_i,
    input  logic [11:0]      addr_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    output logic             err_o,
    input  logic [VEC_W-1:0] act_vec_i,
    input  logic [VEC_W-1:0] pend_vec_i,
    input  logic             pend_vld_i,
    input  logic             ext_pend_i,
    input  logic             nmi_pend_i,
    input  logic             psv_pend_i,
    input  logic             tick_pend_i,
    input  logic [6:0]       hnd_act_i,
    input  logic [3:0]       hnd_pend_i,
    output logic             nmi_set_o,
    output logic             psv_set_o,
    output logic             psv_clr_o,
    output logic             tick_set_o,
    output logic             tick_clr_o,
    output logic             trig_vld_o,
    output logic [VEC_W-1:0] trig_num_o,
    output logic [2:0]       fault_en_o,
    output logic [31:0]      vtor_o,
    output logic             sysrst_o
);
    wr_eff_t     weff;
    logic [31:0] rd_word;
    logic        rd_hit;
    bank_t       st_d, st_q;

    sysctl_wdec #(.NUM_IRQ(NUM_IRQ)) u_wdec (
        .wr_en_i (wr_en_i),
        .addr_i  (addr_i),
        .wdata_i (wdata_i),
        .eff_o   (weff)
    );

    sysctl_rmux #(.NUM_IRQ(NUM_IRQ)) u_rmux (
        .addr_i      (addr_i),
        .act_vec_i   (act_vec_i),
        .pend_vec_i  (pend_vec_i),
        .pend_vld_i  (pend_vld_i),
        .ext_pend_i  (ext_pend_i),
        .nmi_pend_i  (nmi_pend_i),
        .psv_pend_i  (psv_pend_i),
        .tick_pend_i (tick_pend_i),
        .hnd_act_i   (hnd_act_i),
        .hnd_pend_i  (hnd_pend_i),
        .fen_i       (st_q.fen),
        .vtb_hi_i    (st_q.vtb_hi),
        .data_o      (rd_word),
        .hit_o       (rd_hit)
    );

    always_comb begin
        st_d          = st_q;
        st_d.nmi_set  = weff.nmi_set;
        st_d.psv_set  = weff.psv_set;
        st_d.psv_clr  = weff.psv_clr;
        st_d.tick_set = weff.tick_set;
        st_d.tick_clr = weff.tick_clr;
        st_d.trig_vld = weff.trig_vld;
        st_d.trig_num = weff.trig_num;
        st_d.rst_req  = weff.rst_req;
        st_d.err      = (wr_en_i & ~weff.hit) | (rd_en_i & ~rd_hit);
        st_d.rdata    = (rd_en_i & rd_hit) ? rd_word : '0;
        if (weff.vtb_we) st_d.vtb_hi = wdata_i[31:7];
        if (weff.fen_we) st_d.fen    = wdata_i[18:16];
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign rdata_o    = st_q.rdata;
    assign err_o      = st_q.err;
    assign nmi_set_o  = st_q.nmi_set;
    assign psv_set_o  = st_q.psv_set;
    assign psv_clr_o  = st_q.psv_clr;
    assign tick_set_o = st_q.tick_set;
    assign tick_clr_o = st_q.tick_clr;
    assign trig_vld_o = st_q.trig_vld;
    assign trig_num_o = st_q.trig_num;
    assign fault_en_o = st_q.fen;
    assign vtor_o     = {st_q.vtb_hi, 7'd0};
    assign sysrst_o   = st_q.rst_req;
endmodule

module sysctl_bank_chk
    import sysctl_pkg::*;
#(
    parameter int unsigned NUM_IRQ = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en_i,
    input logic [11:0]      addr_i,
    input logic [15:0]      key_i,
    input logic             b28_i,
    input logic             b26_i,
    input logic             b2_i,
    input logic             psv_set_o,
    input logic             psv_clr_o,
    input logic             tick_set_o,
    input logic             tick_clr_o,
    input logic             trig_vld_o,
    input logic [VEC_W-1:0] trig_num_o,
    input logic [31:0]      vtor_o,
    input logic             sysrst_o
);
    // R6
    rst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        sysrst_o |=> !sysrst_o);
    // R6
    rst_key_chk: assert property (@(posedge clk) disable iff (rst)
        sysrst_o |-> $past(wr_en_i && addr_i == OFS_RST && key_i == RST_KEY && b2_i));
    // R3
    psv_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == OFS_ICS && b28_i) |=> (psv_set_o && !psv_clr_o));
    // R4
    tick_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en_i && addr_i == OFS_ICS && b26_i) |=> (tick_set_o && !tick_clr_o));
    // R7
    vtor_align_chk: assert property (@(posedge clk) disable iff (rst)
        vtor_o[6:0] == 7'd0);
    // R9
    trig_range_chk: assert property (@(posedge clk) disable iff (rst)
        trig_vld_o |-> (32'(trig_num_o) < 32'(NUM_IRQ)));
endmodule

bind sysctl_bank sysctl_bank_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .key_i      (wdata_i[31:16]),
    .b28_i      (wdata_i[28]),
    .b26_i      (wdata_i[26]),
    .b2_i       (wdata_i[2]),
    .psv_set_o  (psv_set_o),
    .psv_clr_o  (psv_clr_o),
    .tick_set_o (tick_set_o),
    .tick_clr_o (tick_clr_o),
    .trig_vld_o (trig_vld_o),
    .trig_num_o (trig_num_o),
    .vtor_o     (vtor_o),
    .sysrst_o   (sysrst_o)
);

// File: tb/sysctl_bank_bench.sv
module sysctl_bank_bench;
    localparam int NIRQ = 64;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        wr = 0, rd = 0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [8:0]  act_vec = '0, pend_vec = '0;
    logic        pend_vld = 0, ext_pend = 0, nmi_p = 0, psv_p = 0, tick_p = 0;
    logic [6:0]  h_act = '0;
    logic [3:0]  h_pend = '0;

    logic [31:0] rdata, vtor;
    logic        err, nmi_set, psv_set, psv_clr, tick_set, tick_clr, trig_vld, sysrst;
    logic [8:0]  trig_num;
    logic [2:0]  fen;

    sysctl_bank #(.NUM_IRQ(NIRQ)) u_sysctl_bank (
        .clk(clk), .rst(rst), .wr_en_i(wr), .rd_en_i(rd), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
        .act_vec_i(act_vec), .pend_vec_i(pend_vec), .pend_vld_i(pend_vld),
        .ext_pend_i(ext_pend), .nmi_pend_i(nmi_p), .psv_pend_i(psv_p),
        .tick_pend_i(tick_p), .hnd_act_i(h_act), .hnd_pend_i(h_pend),
        .nmi_set_o(nmi_set), .psv_set_o(psv_set), .psv_clr_o(psv_clr),
        .tick_set_o(tick_set), .tick_clr_o(tick_clr), .trig_vld_o(trig_vld),
        .trig_num_o(trig_num), .fault_en_o(fen), .vtor_o(vtor), .sysrst_o(sysrst)
    );

    int n_chk = 0, n_fail = 0;

    // reference model state
    logic [31:0] m_vtor = '0;
    logic [2:0]  m_fen = '0;
    logic [31:0] e_rdata = '0;
    logic        e_err = 0, e_nmi = 0, e_psvs = 0, e_psvc = 0, e_ticks = 0, e_tickc = 0;
    logic        e_trig = 0, e_rst = 0;
    logic [8:0]  e_num = '0;
    string       rd_tag = "R1";

    task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, nm, act, exp);
        end
    endtask

    task automatic compare_all();
        chk(rd_tag, "rdata", rdata, e_rdata);
        chk("R11", "err", 32'(err), 32'(e_err));
        chk("R2", "nmi_set", 32'(nmi_set), 32'(e_nmi));
        chk("R3", "psv_set", 32'(psv_set), 32'(e_psvs));
        chk("R3", "psv_clr", 32'(psv_clr), 32'(e_psvc));
        chk("R4", "tick_set", 32'(tick_set), 32'(e_ticks));
        chk("R4", "tick_clr", 32'(tick_clr), 32'(e_tickc));
        chk("R9", "trig_vld", 32'(trig_vld), 32'(e_trig));
        chk("R9", "trig_num", 32'(trig_num), 32'(e_num));
        chk("R6", "sysrst", 32'(sysrst), 32'(e_rst));
        chk("R8", "fault_en", 32'(fen), 32'(m_fen));
        chk("R7", "vtor", vtor, m_vtor);
    endtask

    function automatic logic [31:0] ics_expect();
        logic [31:0] v = 0;
        v = v | 32'(act_vec);
        if (pend_vld) v = v | (32'(pend_vec) << 12);
        if (ext_pend) v = v | (32'd1 << 22);
        if (tick_p)   v = v | (32'd1 << 26);
        if (psv_p)    v = v | (32'd1 << 28);
        if (nmi_p)    v = v | (32'd1 << 31);
        return v;
    endfunction

    function automatic logic [31:0] hnd_expect();
        int pos [7] = '{0, 1, 3, 7, 8, 10, 11};
        logic [31:0] v = 0;
        for (int i = 0; i < 7; i++) if (h_act[i]) v = v | (32'd1 << pos[i]);
        v = v | (32'(h_pend) << 12) | (32'(m_fen) << 16);
        return v;
    endfunction

    task automatic step(input logic w, input logic r, input logic [11:0] a, input logic [31:0] d);
        logic wmap, rmap;
        wmap = (a == 12'hD04) || (a == 12'hD08) || (a == 12'hD0C) || (a == 12'hD24) || (a == 12'hF00);
        rmap = (a == 12'h004) || (a == 12'hD04) || (a == 12'hD08) || (a == 12'hD0C) || (a == 12'hD24);
        e_rdata = 0;
        rd_tag  = "R1";
        if (r && rmap) begin
            case (a)
                12'h004: begin e_rdata = NIRQ / 32 - 1; rd_tag = "R10"; end
                12'hD04: begin e_rdata = ics_expect(); rd_tag = "R5"; end
                12'hD08: begin e_rdata = m_vtor; rd_tag = "R7"; end
                12'hD0C: begin e_rdata = 32'hFA050000; rd_tag = "R6"; end
                default: begin e_rdata = hnd_expect(); rd_tag = "R8"; end
            endcase
        end else if (r) rd_tag = "R11";
        e_err   = (w && !wmap) || (r && !rmap);
        e_nmi   = w && a == 12'hD04 && d[31];
        e_psvs  = w && a == 12'hD04 && d[28];
        e_psvc  = w && a == 12'hD04 && d[27] && !d[28];
        e_ticks = w && a == 12'hD04 && d[26];
        e_tickc = w && a == 12'hD04 && d[25] && !d[26];
        e_trig  = w && a == 12'hF00 && (int'(d & 32'h1FF) < NIRQ);
        e_num   = e_trig ? d[8:0] : 9'd0;
        e_rst   = w && a == 12'hD0C && d[31:16] == 16'h05FA && d[2];
        if (w && a == 12'hD08) m_vtor = d & 32'hFFFFFF80;
        if (w && a == 12'hD24) m_fen  = d[18:16];
        wr = w; rd = r; addr = a; wdata = d;
        @(negedge clk);
        compare_all();
        wr = 0; rd = 0;
    endtask

    initial begin : watchdog
        #800000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare_all(); // R1 during reset
        rst = 0;
        step(0, 0, 12'h000, 0);               // R1 first cycle after reset
        step(0, 1, 12'h004, 0);               // R10
        step(1, 0, 12'hD04, 32'h8000_0000);   // R2
        step(1, 0, 12'hD04, 32'h1800_0000);   // R3 set wins
        step(1, 0, 12'hD04, 32'h0800_0000);   // R3 clear
        step(1, 0, 12'hD04, 32'h0600_0000);   // R4 set wins
        step(1, 0, 12'hD04, 32'h0200_0000);   // R4 clear
        step(1, 0, 12'hD04, 32'h9A00_0000);   // R2 R3 R4 combined
        act_vec = 9'd15; pend_vec = 9'd40; pend_vld = 1; ext_pend = 1; nmi_p = 1;
        step(0, 1, 12'hD04, 0);               // R5
        act_vec = 9'h1FF; pend_vec = 9'h1AB; pend_vld = 0; ext_pend = 0; nmi_p = 0;
        psv_p = 1; tick_p = 1;
        step(0, 1, 12'hD04, 0);               // R5 no pending vector
        step(1, 0, 12'hD0C, 32'h05FA_0004);   // R6 keyed reset
        step(0, 0, 12'h000, 0);               // R6 pulse over
        step(1, 0, 12'hD0C, 32'h05FB_0004);   // R6 wrong key
        step(1, 0, 12'hD0C, 32'h05FA_0003);   // R6 key, no request bit
        step(0, 1, 12'hD0C, 0);               // R6 read constant
        step(1, 1, 12'hD08, 32'hFFFF_FFFF);   // R7 read sees old value
        step(0, 1, 12'hD08, 0);               // R7
        step(1, 0, 12'hD08, 32'h2000_04C5);   // R7
        step(1, 0, 12'hD24, 32'hFFF7_FFFF);   // R8 enables 3
        step(1, 0, 12'hD24, 32'h0002_0000);   // R8 bus only
        h_act = 7'b1010101; h_pend = 4'b1001;
        step(0, 1, 12'hD24, 0);               // R8
        h_act = 7'b0101010; h_pend = 4'b0110;
        step(0, 1, 12'hD24, 0);               // R8
        step(1, 0, 12'hF00, 32'h0000_0005);   // R9
        step(1, 0, 12'hF00, 32'h0000_003F);   // R9 top number
        step(1, 0, 12'hF00, 32'h0000_0040);   // R9 out of range
        step(1, 0, 12'hF00, 32'h0000_01FF);   // R9 out of range
        step(1, 0, 12'hF00, 32'hFFFF_FE03);   // R9 upper bits ignored
        step(0, 1, 12'h100, 0);               // R11 unmapped read
        step(1, 0, 12'hD10, 32'hFFFF_FFFF);   // R11 unmapped write
        step(1, 0, 12'h004, 32'hFFFF_FFFF);   // R11 write to read-only
        step(0, 1, 12'hF00, 0);               // R11 read of write-only
        step(0, 1, 12'hD08, 0);               // R11 vtor unchanged
        step(0, 1, 12'hD24, 0);               // R11 enables unchanged
        step(0, 0, 12'h000, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule